// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Read Slave

This block models a small two-wire serial EEPROM that a master drives purely in software, one line update at a time. Each time the master writes new clock and data levels it pulses a valid strobe; the block compares the new levels with the ones it stored on the previous strobe. From that comparison it recognises start and stop conditions, samples bits on rising clock edges, and returns the level it leaves on the data line. That level is either the master's own level or a low/high bit the slave forces onto the line.

A transaction is paced by one small tick counter. A start condition begins a command byte. An acknowledge slot follows, then an address byte and a second acknowledge slot. At the close of the address byte the addressed byte of a 256-entry read-only image is loaded into a shift register. When the command's lowest bit requests a read, that register is shifted out, most significant bit first, during the address byte of the next transaction. Writes into the image, sequential reads, device address matching and clock stretching are not part of the block.

Top module: `eeprom_bb_slave`

## Requirements
- R1: While reset is low, and on the first clock after it is released, the returned data level is 1. The tick counter, acknowledge flag, command, address and data registers are all cleared, so the next read returns byte 0x00.
- R2: A clock edge with the valid strobe low changes nothing: the returned level holds and transaction progress is kept.
- R3: A start is a strobe where the clock stays high (stored 1, new 1) and data goes from 1 to 0. It always restarts the transaction at the first command bit, abandoning any partial transfer.
- R4: With no transaction in progress and no acknowledge pending, every strobe except a start leaves the progress unchanged. The returned level then simply follows the master's data level.
- R5: A bit is taken only on a rising clock edge (stored 0, new 1) whose data level equals the stored level. A rising edge with changed data is not counted. Command bits enter most significant bit first.
- R6: After the eighth command bit an acknowledge is pending. The next rising clock edge returns 0, consumes the acknowledge and counts no bit.
- R7: When bit 0 of the command is 1, the returned level on each of the eight address-bit rising edges is the data register's MSB, and the register then shifts left by one.
- R8: When bit 0 of the command is 0, the returned level follows the master's data level throughout the address byte.
- R9: The eighth address bit loads the image byte at the collected address into the data register and makes an acknowledge pending. After that acknowledge slot, further rising edges are ignored until a start.
- R10: The image holds 256 bytes. Addresses 0x00, 0x01, 0x02 and 0x03 hold 0x80, 0x08, 0x04 and 0x0D; every other address holds 0x00.
- R11: A stop (clock stays high, data goes from 0 to 1) does not clear transaction progress; bit counting continues with the next rising edge.
- R12: The returned level is registered. It reflects a strobe on the clock edge that captures that strobe, and it is stored as the previous data level for the next comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Strobe: new clock and data levels are present |
| scl_i | input | 1 | Clock level written by the master |
| sda_i | input | 1 | Data level written by the master |
| sda_o | output | 1 | Data level seen on the line after the slave's override |

## Verification
Every result of this block appears on the returned data level one clock after the strobe that carries the line update. Each stimulus step therefore raises the strobe at a falling clock edge and drops it at the next falling edge. The output is compared at that second falling edge, half a cycle after the capturing rising edge. Acknowledge slots, shifted-out read bits and echoed master bits are all predicted per strobe. Fetched bytes are checked one transaction later, in the address byte of the following read. Tests for ignored strobes and stop conditions probe the counter position by checking that the acknowledge arrives on exactly the expected rising edge.

// File: rtl/eeprom_bb_pkg.sv
// Shared definitions for the bit-banged EEPROM slave.
// Assumes the image is byte-wide; wider parameterisations zero-extend it.
package eeprom_bb_pkg;

    // Constant image contents: a handful of leading bytes, zero elsewhere.
    function automatic logic [7:0] image_byte(input int unsigned idx);
        case (idx)
            0:       image_byte = 8'h80;
            1:       image_byte = 8'h08;
            2:       image_byte = 8'h04;
            3:       image_byte = 8'h0D;
            default: image_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/eeprom_bb_line_mon.sv
// Classifies one line update against the previously stored levels.
// Purely combinational; assumes the stored levels come from the sequencer.
module eeprom_bb_line_mon (
    input  logic scl_i,
    input  logic sda_i,
    input  logic scl_q,
    input  logic sda_q,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic same_o
);
    // Data moving while clock is held high marks a start or a stop.
    always_comb begin
        start_o = scl_q && scl_i && sda_q && !sda_i;
        stop_o  = scl_q && scl_i && !sda_q && sda_i;
        rise_o  = !scl_q && scl_i;
        same_o  = (sda_q == sda_i);
    end
endmodule

// File: rtl/eeprom_bb_rom.sv
// Read-only byte image, combinational read.
// Assumes DEPTH = 2**BYTE_W entries, contents taken from the package.
module eeprom_bb_rom
    import eeprom_bb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DEPTH = 1 << BYTE_W
) (
    input  logic [BYTE_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [BYTE_W-1:0] img [DEPTH];

    // One constant per entry, sized to the configured byte width.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_img
        assign img[gi] = BYTE_W'(image_byte(gi));
    end

    // Lookup of the addressed entry.
    assign rd_data_o = img[rd_addr_i];
endmodule

// File: rtl/eeprom_bb_seq.sv
// Transaction sequencer: tick counter, acknowledge flag, command, address
// and data shift registers, plus the stored line levels.
// Assumes event flags from eeprom_bb_line_mon and an external image lookup
// fed with the next address value.
module eeprom_bb_seq #(
    parameter int BYTE_W = 8,
    localparam int TICK_W = $clog2(2 * BYTE_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              same_i,
    output logic [BYTE_W-1:0] rom_addr_o,
    input  logic [BYTE_W-1:0] rom_data_i,
    output logic              scl_q_o,
    output logic              sda_q_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              ack_o
);
    localparam logic [TICK_W-1:0] TICK_FIRST = TICK_W'(1);
    localparam logic [TICK_W-1:0] CMD_END    = TICK_W'(BYTE_W + 1);
    localparam logic [TICK_W-1:0] ADDR_END   = TICK_W'(2 * BYTE_W + 1);

    logic [TICK_W-1:0] tick_q, tick_n, tick_inc;
    logic              ack_q, ack_n;
    logic [BYTE_W-1:0] cmd_q, cmd_n;
    logic [BYTE_W-1:0] addr_q, addr_n, addr_shift;
    logic [BYTE_W-1:0] data_q, data_n;
    logic              scl_q, sda_q, drive;

    // Address with the incoming bit appended; also the image lookup index.
    assign addr_shift = {addr_q[BYTE_W-2:0], sda_i};
    assign rom_addr_o = addr_shift;
    assign tick_inc   = tick_q + TICK_FIRST;

    // Next-state decision for one strobed line update.
    always_comb begin
        tick_n = tick_q;
        ack_n  = ack_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        data_n = data_q;
        drive  = sda_i;
        if (start_i || stop_i) begin
            if (start_i) begin
                tick_n = TICK_FIRST;
                cmd_n  = '0;
            end
        end else if ((tick_q == '0) && !ack_q) begin
            drive = sda_i;
        end else if (rise_i) begin
            if (ack_q) begin
                drive = 1'b0;
                ack_n = 1'b0;
            end else if (same_i) begin
                if (tick_q < CMD_END) begin
                    cmd_n  = {cmd_q[BYTE_W-2:0], sda_i};
                    tick_n = tick_inc;
                    if (tick_inc == CMD_END) begin
                        ack_n = 1'b1;
                    end
                end else if (tick_q < ADDR_END) begin
                    if (cmd_q[0]) begin
                        drive = data_q[BYTE_W-1];
                    end
                    addr_n = addr_shift;
                    data_n = {data_q[BYTE_W-2:0], 1'b0};
                    tick_n = tick_inc;
                    if (tick_inc == ADDR_END) begin
                        data_n = rom_data_i;
                        ack_n  = 1'b1;
                        tick_n = '0;
                    end
                end else begin
                    drive = 1'b0;
                end
            end
        end
    end

    // State and stored line levels advance only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
            ack_q  <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else if (valid_i) begin
            tick_q <= tick_n;
            ack_q  <= ack_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            data_q <= data_n;
            scl_q  <= scl_i;
            sda_q  <= drive;
        end
    end

    assign scl_q_o = scl_q;
    assign sda_q_o = sda_q;
    assign tick_o  = tick_q;
    assign ack_o   = ack_q;
endmodule

// File: rtl/eeprom_bb_slave.sv
// Top of the bit-banged EEPROM read slave.
// Assumes the master presents each new clock/data pair with a one-cycle
// valid strobe; the returned data level is registered.
module eeprom_bb_slave #(
    parameter int BYTE_W = 8,
    localparam int TICK_W = $clog2(2 * BYTE_W + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);
    logic              ev_start, ev_stop, ev_rise, ev_same;
    logic              line_scl_q, line_sda_q;
    logic [TICK_W-1:0] tick_w;
    logic              ack_w;
    logic [BYTE_W-1:0] rom_addr, rom_data;

    // Edge and condition classification.
    eeprom_bb_line_mon u_mon (
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_q   (line_scl_q),
        .sda_q   (line_sda_q),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .same_o  (ev_same)
    );

    // Transaction state.
    eeprom_bb_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .sda_i      (sda_i),
        .scl_i      (scl_i),
        .start_i    (ev_start),
        .stop_i     (ev_stop),
        .rise_i     (ev_rise),
        .same_i     (ev_same),
        .rom_addr_o (rom_addr),
        .rom_data_i (rom_data),
        .scl_q_o    (line_scl_q),
        .sda_q_o    (line_sda_q),
        .tick_o     (tick_w),
        .ack_o      (ack_w)
    );

    // Byte image.
    eeprom_bb_rom #(.BYTE_W(BYTE_W)) u_rom (
        .rd_addr_i (rom_addr),
        .rd_data_o (rom_data)
    );

    assign sda_o = line_sda_q;
endmodule

// File: rtl/eeprom_bb_slave_chk.sv
// Property checker for eeprom_bb_slave, attached by bind below.
// Observes ports plus the stored line levels, tick counter and ack flag.
module eeprom_bb_slave_chk #(
    parameter int BYTE_W = 8,
    localparam int TICK_W = $clog2(2 * BYTE_W + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_o,
    input logic              scl_q,
    input logic              sda_q,
    input logic [TICK_W-1:0] tick,
    input logic              ack
);
    localparam logic [TICK_W-1:0] LAST_CMD  = TICK_W'(BYTE_W);
    localparam logic [TICK_W-1:0] LAST_ADDR = TICK_W'(2 * BYTE_W);

    assert_release_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> sda_o);

    assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(sda_o));

    assert_start_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && scl_q && scl_i && sda_q && !sda_i) |=> (tick == TICK_W'(1)));

    assert_idle_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (tick == '0) && !ack && !(scl_q && scl_i && sda_q && !sda_i))
        |=> ((tick == '0) && !ack));

    assert_cmd_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ack && (tick == LAST_CMD) && !scl_q && scl_i && (sda_q == sda_i))
        |=> (ack && (tick == LAST_CMD + TICK_W'(1))));

    assert_ack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ack && !scl_q && scl_i) |=> (!sda_o && !ack));

    assert_fetch_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !ack && (tick == LAST_ADDR) && !scl_q && scl_i && (sda_q == sda_i))
        |=> (ack && (tick == '0)));

    assert_tick_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick <= LAST_ADDR);
endmodule

bind eeprom_bb_slave eeprom_bb_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_o   (sda_o),
    .scl_q   (line_scl_q),
    .sda_q   (line_sda_q),
    .tick    (tick_w),
    .ack     (ack_w)
);

// File: tb/eeprom_bb_slave_test.sv
// Self-checking bench: a vector table for one write-mode transaction,
// then directed tests for reads, ignored strobes, stops, restarts, reset.
module eeprom_bb_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_out;
    int   checks = 0;
    int   errs = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    eeprom_bb_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (strobe),
        .scl_i   (scl),
        .sda_i   (sda),
        .sda_o   (sda_out)
    );

    // Entries {scl, sda, expected returned level}: start, command 0xA0,
    // ack, address 0x03, ack, clock low.
    localparam int NVEC = 39;
    localparam logic [2:0] VEC [NVEC] = '{
        3'b111, 3'b100,
        3'b011, 3'b111, 3'b000, 3'b100, 3'b011, 3'b111, 3'b000, 3'b100,
        3'b000, 3'b100, 3'b000, 3'b100, 3'b000, 3'b100, 3'b000, 3'b100,
        3'b011, 3'b110,
        3'b000, 3'b100, 3'b000, 3'b100, 3'b000, 3'b100, 3'b000, 3'b100,
        3'b000, 3'b100, 3'b000, 3'b100, 3'b011, 3'b111, 3'b011, 3'b111,
        3'b011, 3'b110,
        3'b011
    };

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    endtask

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: sda_o=%0b expected %0b", req, got, exp);
        end
    endtask

    // One strobed line update; result checked a cycle later.
    task automatic apply(input logic c, input logic d, input logic exp, input string req);
        @(negedge clk);
        strobe = 1'b1;
        scl = c;
        sda = d;
        @(negedge clk);
        strobe = 1'b0;
        chk(sda_out, exp, req);
    endtask

    task automatic send_bit(input logic b, input logic exp_hi, input string req);
        apply(1'b0, b, b, req);
        apply(1'b1, b, exp_hi, req);
    endtask

    task automatic ack_slot(input string req);
        apply(1'b0, 1'b1, 1'b1, req);
        apply(1'b1, 1'b1, 1'b0, req);
    endtask

    task automatic start_cond();
        apply(1'b0, 1'b1, 1'b1, "R4");
        apply(1'b1, 1'b1, 1'b1, "R4");
        apply(1'b1, 1'b0, 1'b0, "R3");
    endtask

    // From clock high with data low: stop, then start, with no rising edge.
    task automatic restart_cond();
        apply(1'b1, 1'b1, 1'b1, "R11");
        apply(1'b1, 1'b0, 1'b0, "R3");
    endtask

    task automatic send_byte(input logic [7:0] b, input logic rd, input logic [7:0] shown, input string req);
        for (int i = 7; i >= 0; i--) begin
            send_bit(b[i], rd ? shown[i] : b[i], req);
        end
    endtask

    task automatic txn(input logic [7:0] cmd, input logic [7:0] addr, input logic [7:0] shown, input string req);
        start_cond();
        send_byte(cmd, 1'b0, 8'h00, "R5");
        ack_slot("R6");
        send_byte(addr, cmd[0], shown, req);
        ack_slot("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            report();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(sda_out, 1'b1, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk(sda_out, 1'b1, "R1");

        // R5 R6 R8 R12: table-driven write-mode transaction to address 3
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][2], VEC[i][1], VEC[i][0], "R5 R6 R8 R12");
        end

        // R7 R10: each read shows the byte fetched by the previous transaction
        txn(8'hA1, 8'h00, 8'h0D, "R7 R10");
        txn(8'hA1, 8'h01, 8'h80, "R7 R10");
        txn(8'hA1, 8'h02, 8'h08, "R7 R10");
        txn(8'hA1, 8'h40, 8'h04, "R7 R10");
        txn(8'hA1, 8'h00, 8'h00, "R7 R10");
        // R8 R9: write mode echoes but still fetches
        txn(8'hA0, 8'h03, 8'h00, "R8");
        txn(8'hA1, 8'h00, 8'h0D, "R9");

        // R2: strobe low hides line changes and keeps progress
        start_cond();
        send_bit(1'b1, 1'b1, "R2");
        send_bit(1'b0, 1'b0, "R2");
        send_bit(1'b1, 1'b1, "R2");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            strobe = 1'b0;
            scl = k[0];
            sda = k[1];
            @(negedge clk);
            chk(sda_out, 1'b1, "R2");
        end
        for (int k = 0; k < 5; k++) send_bit(1'b0, 1'b0, "R2");
        ack_slot("R2");

        // R5: rising edge with changed data is not a bit
        restart_cond();
        send_bit(1'b1, 1'b1, "R5");
        send_bit(1'b0, 1'b0, "R5");
        send_bit(1'b1, 1'b1, "R5");
        apply(1'b0, 1'b0, 1'b0, "R5");
        apply(1'b1, 1'b1, 1'b1, "R5");
        for (int k = 0; k < 4; k++) send_bit(1'b0, 1'b0, "R5");
        send_bit(1'b1, 1'b1, "R5");
        ack_slot("R5");

        // R11: stop in the middle of the command keeps counting
        restart_cond();
        send_bit(1'b1, 1'b1, "R11");
        send_bit(1'b0, 1'b0, "R11");
        send_bit(1'b1, 1'b1, "R11");
        send_bit(1'b0, 1'b0, "R11");
        apply(1'b1, 1'b1, 1'b1, "R11");
        send_bit(1'b0, 1'b0, "R11");
        send_bit(1'b0, 1'b0, "R11");
        send_bit(1'b0, 1'b0, "R11");
        send_bit(1'b1, 1'b1, "R11");
        ack_slot("R11");

        // R3: start after five bits restarts the command byte
        restart_cond();
        for (int k = 0; k < 5; k++) send_bit(1'b1, 1'b1, "R3");
        apply(1'b1, 1'b0, 1'b0, "R3");
        send_byte(8'hF0, 1'b0, 8'h00, "R3");
        ack_slot("R3");

        // R1: reset in mid-transaction, then R4 idle edges never acknowledge
        restart_cond();
        send_bit(1'b1, 1'b1, "R1");
        send_bit(1'b1, 1'b1, "R1");
        send_bit(1'b1, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        scl = 1'b1;
        sda = 1'b1;
        @(negedge clk);
        chk(sda_out, 1'b1, "R1");
        for (int k = 0; k < 9; k++) send_bit(1'b1, 1'b1, "R4");
        txn(8'hA1, 8'h00, 8'h00, "R1");

        done = 1'b1;
        report();
        $finish;
    end
endmodule